// File: doc/BRIEF.md
# Switchable-window ROM bank mapper

This block decodes an 8-bit CPU bus with a 16-bit address for a cartridge that holds more program ROM than the CPU can see at once. A bank register loads from the CPU data bus on any write to the upper half of the address space. It drives the upper ROM address lines, so a 16KiB window at $8000-$BFFF can be switched. When CPU address bit 14 is high ($C000-$FFFF), the ROM bank lines are forced to all ones, and that range always shows the last bank.

The same register write also loads a two-bit mirroring field. That field picks the level driven onto the nametable RAM select line: tied low, tied high, following video address bit 10, or following video address bit 11. The ROM output enable is asserted only on reads, so a bank-select write never finds the ROM driving the data bus against the CPU. A work-RAM chip enable decodes $6000-$7FFF while the bus strobe is high.

The block runs on a fast system clock. The CPU strobe is sampled on that clock, and a register write takes effect on the clock edge at which a high-to-low transition of the strobe is seen.

Top module: `prg_bank_mapper`

## Requirements
- R1: When the strobe is seen falling (high on one clock edge, low on the next) with cpu_rw = 0 and cpu_addr[15] = 1, the bank register loads cpu_data[2:0] on that edge.
- R2: The same write loads the mirroring field from cpu_data[5:4].
- R3: A strobe fall with cpu_rw = 1, or with cpu_addr[15] = 0, leaves both the bank register and the mirroring field unchanged.
- R4: rom_bank is all ones (3'b111) whenever cpu_addr[14] = 1. Otherwise it equals the bank register.
- R5: rom_oe_n is 0 only when cpu_rw = 1 and cpu_addr[15] = 1. In particular, it is 1 during every write.
- R6: wram_ce_n is 0 only when cpu_addr[15:13] = 3'b011 and cpu_m2 = 1.
- R7: ciram_a10 follows the mirroring field: 2'b00 gives 0, 2'b01 gives 1, 2'b10 gives ppu_a10 (vertical arrangement), and 2'b11 gives ppu_a11 (horizontal arrangement).
- R8: A synchronous active-low reset clears the bank register and the mirroring field to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the CPU bus |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus (write data) |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_m2 | input | 1 | CPU bus strobe, high during the data phase |
| ppu_a10 | input | 1 | Video address bit 10 |
| ppu_a11 | input | 1 | Video address bit 11 |
| rom_bank | output | 3 | ROM address lines above the 16KiB window |
| rom_oe_n | output | 1 | ROM output enable, active low |
| wram_ce_n | output | 1 | Work RAM chip enable, active low |
| ciram_a10 | output | 1 | Nametable RAM bank select |

## Verification
The bench aims writes just outside the decoded range ($6000) and read-type strobes at $8000. A design that decoded too widely or ignored R/W would then show a new bank in the switchable window. It reads $C000 after every bank write; a design that passed the latched value through there would lose the fixed last bank. It sets the two video address bits to opposite levels under each mirroring code, so a swapped or mis-decoded select shows up at once. It also checks that the ROM enable stays off during a write cycle and that a mid-run reset brings bank 0 back.

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper #(
  parameter int BANK_W  = 3,
  parameter int MIR_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_data,
  input  logic              cpu_rw,
  input  logic              cpu_m2,
  input  logic              ppu_a10,
  input  logic              ppu_a11,
  output logic [BANK_W-1:0] rom_bank,
  output logic              rom_oe_n,
  output logic              wram_ce_n,
  output logic              ciram_a10
);
  localparam logic [2:0] WRAM_SEG = 3'b011;

  logic [BANK_W-1:0] bank_q;
  logic [1:0]        mir_q;
  logic              m2_q;

  logic strobe_fall, reg_hit;
  assign strobe_fall = m2_q & ~cpu_m2;
  assign reg_hit     = cpu_addr[15] & ~cpu_rw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0;
      mir_q  <= '0;
      m2_q   <= 1'b0;
    end else begin
      m2_q <= cpu_m2;
      if (strobe_fall && reg_hit) begin
        bank_q <= cpu_data[BANK_W-1:0];
        mir_q  <= cpu_data[MIR_LSB+1:MIR_LSB];
      end
    end
  end

  assign rom_bank  = cpu_addr[14] ? '1 : bank_q;
  assign rom_oe_n  = ~(cpu_rw & cpu_addr[15]);
  assign wram_ce_n = ~((cpu_addr[15:13] == WRAM_SEG) & cpu_m2);

  always_comb begin
    case (mir_q)
      2'b00:   ciram_a10 = 1'b0;
      2'b01:   ciram_a10 = 1'b1;
      2'b10:   ciram_a10 = ppu_a10;
      default: ciram_a10 = ppu_a11;
    endcase
  end
endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk #(
  parameter int BANK_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpu_addr,
  input logic [7:0]        cpu_data,
  input logic              cpu_rw,
  input logic              cpu_m2,
  input logic              ppu_a10,
  input logic [BANK_W-1:0] rom_bank,
  input logic              rom_oe_n,
  input logic              wram_ce_n,
  input logic              ciram_a10,
  input logic [BANK_W-1:0] bank_q,
  input logic [1:0]        mir_q,
  input logic              m2_q
);
  // R1
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m2_q && !cpu_m2 && !cpu_rw && cpu_addr[15]) |=> (bank_q == $past(cpu_data[BANK_W-1:0])));

  // R3
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(m2_q && !cpu_m2 && !cpu_rw && cpu_addr[15]) |=> ($stable(bank_q) && $stable(mir_q)));

  // R4
  fixed_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[14] |-> (&rom_bank));

  // R5
  write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rw |-> rom_oe_n);

  // R6
  wram_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wram_ce_n |-> (cpu_addr[15:13] == 3'b011 && cpu_m2));

  // R7
  mirror_vert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mir_q == 2'b10) |-> (ciram_a10 == ppu_a10));
endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(.BANK_W(BANK_W)) u_chk (.*);

// File: tb/sim_prg_bank_mapper.sv
module sim_prg_bank_mapper;
  logic clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic cpu_rw = 1, cpu_m2 = 0, ppu_a10 = 0, ppu_a11 = 0;
  logic [2:0] rom_bank;
  logic rom_oe_n, wram_ce_n, ciram_a10;

  always #4 clk = ~clk;

  prg_bank_mapper u0 (.*);

  typedef struct {
    logic [2:0] bank;
    logic oe_n;
    logic wram_n;
    logic ciram;
    string tag;
  } exp_t;

  exp_t sb[$];
  event sample_ev;
  int total = 0, bad = 0;
  bit finished = 0;
  logic [2:0] m_bank = 0;
  logic [1:0] m_mir = 0;

  always @(sample_ev) begin
    exp_t e;
    while (sb.size() > 0) begin
      e = sb.pop_front();
      total++;
      if (rom_bank !== e.bank || rom_oe_n !== e.oe_n ||
          wram_ce_n !== e.wram_n || ciram_a10 !== e.ciram) begin
        bad++;
        $display("FAIL %s: bank/oe_n/wram_n/ciram got %b/%b/%b/%b exp %b/%b/%b/%b",
                 e.tag, rom_bank, rom_oe_n, wram_ce_n, ciram_a10,
                 e.bank, e.oe_n, e.wram_n, e.ciram);
      end
    end
  end

  task automatic strobe(input logic [15:0] a, input logic [7:0] d, input logic rw);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_rw = rw; cpu_m2 = 1;
    @(negedge clk);
    cpu_m2 = 0;
    @(negedge clk);
    cpu_rw = 1;
    if (!rw && a[15]) begin
      m_bank = d[2:0];
      m_mir  = d[5:4];
    end
  endtask

  task automatic probe(input logic [15:0] a, input logic rw, input logic m2,
                       input logic a10, input logic a11, input string tag);
    exp_t e;
    @(negedge clk);
    cpu_addr = a; cpu_rw = rw; cpu_m2 = m2; ppu_a10 = a10; ppu_a11 = a11;
    e.bank   = a[14] ? 3'b111 : m_bank;
    e.oe_n   = !(rw && a[15]);
    e.wram_n = !(a[15:13] == 3'b011 && m2);
    case (m_mir)
      2'b00:   e.ciram = 1'b0;
      2'b01:   e.ciram = 1'b1;
      2'b10:   e.ciram = a10;
      default: e.ciram = a11;
    endcase
    e.tag = tag;
    sb.push_back(e);
    #2 -> sample_ev;
    #1;
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    probe(16'h8000, 1, 1, 1, 1, "R8 reset state");

    strobe(16'h8000, 8'h05, 0);
    probe(16'h8123, 1, 1, 1, 1, "R1 bank load");
    probe(16'hC000, 1, 1, 1, 1, "R4 fixed window");

    strobe(16'hFFFF, 8'h22, 0);
    probe(16'h9000, 1, 1, 1, 0, "R2 R7 vertical a10=1");
    probe(16'h9000, 1, 1, 0, 1, "R7 vertical a10=0");

    strobe(16'hA000, 8'h33, 0);
    probe(16'hA000, 1, 1, 0, 1, "R7 horizontal a11=1");
    probe(16'hA000, 1, 1, 1, 0, "R7 horizontal a11=0");

    strobe(16'hB000, 8'h13, 0);
    probe(16'hB000, 1, 1, 0, 0, "R7 single upper");

    strobe(16'h6000, 8'h06, 0);
    probe(16'h8000, 1, 1, 1, 0, "R3 write below range ignored");
    strobe(16'h8000, 8'h04, 1);
    probe(16'h8000, 1, 1, 1, 0, "R3 read strobe ignored");

    probe(16'h8000, 0, 1, 0, 0, "R5 oe off during write");
    probe(16'hE000, 0, 1, 0, 0, "R5 R4 write in fixed range");
    probe(16'h4000, 1, 1, 0, 0, "R5 oe off below ROM");
    probe(16'h6000, 1, 1, 0, 0, "R6 wram select");
    probe(16'h7FFF, 1, 0, 0, 0, "R6 wram strobe low");
    probe(16'h5FFF, 1, 1, 0, 0, "R6 wram below window");
    probe(16'h8000, 1, 1, 0, 0, "R6 wram above window");

    for (int k = 0; k < 8; k++) begin
      strobe(16'h8000 | 16'(k << 8), 8'(k | ((k & 3) << 4)), 0);
      probe(16'hBFFF, 1, 1, 1, 0, "R1 R2 bank sweep");
      probe(16'hFFFC, 1, 1, 0, 1, "R4 fixed after sweep");
    end

    strobe(16'hC000, 8'h36, 0);
    probe(16'h8000, 1, 1, 0, 1, "R1 write via fixed range");
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    m_bank = 0; m_mir = 0;
    probe(16'h8000, 1, 1, 1, 1, "R8 mid-run reset");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule